// File: doc/BRIEF.md
# Multiplexed LCD Scan Timing Generator

This block produces the digital timing for a multiplexed segment LCD whose segment pins double as key-sense inputs. It holds a 16-byte display store, walks the common lines one slot at a time, and presents the on/off pattern of every segment for the common that is currently selected. Each slot is cut into a display part, where segments are driven, and a key-scan part at its tail, where segment drive is released and a strobe marks the moment to sample the key inputs.

Two geometries are supported: four commons with twenty segments, or eight commons with sixteen segments. The total slot length is fixed per geometry; only the key-scan window inside it is programmable. The geometry and the window code are captured at frame boundaries, so a frame always runs with one consistent setting. Bias voltages and pad drivers sit outside this block and consume its enables and patterns.

Top module: `lcd_scan_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, every output (`com_o`, `seg_o`, `seg_drv_o`, `ks_phase_o`, `ks_strobe_o`, `frame_start_o`) is low, and the captured setting is `mode8_i`=0 with window code 000.
- R2: When running, a slot lasts 110 clocks with `mode8_i`=0 (four commons) and 55 clocks with `mode8_i`=1 (eight commons); `com_o` is one-hot on bit k for common k, advances by one at each slot end and wraps to common 0 after common 3 (four-common geometry) or common 7 (eight-common geometry).
- R3: With window code P on `ks_code_i`, the key-scan part is the last 2*P+2 clocks of the slot in the four-common geometry and the last 2*P+1 clocks in the eight-common geometry; `ks_phase_o` is high exactly then and `seg_drv_o` is high for the rest of the slot.
- R4: `ks_strobe_o` is high for exactly one clock, the last clock of each key-scan part.
- R5: `frame_start_o` is high only on the first clock of the common 0 slot.
- R6: In the four-common geometry, segment 2n comes from bits 3:0 of byte n and segment 2n+1 from bits 7:4, the bit inside the nibble being the common number; bytes 0 to 9 are used and a 1 means on.
- R7: In the eight-common geometry, segment n (n<16) comes from byte n, bit k being common k, a 1 meaning on; `seg_o` bits 16 to 19 stay low.
- R8: While `disp_en_i` or `osc_run_i` is low, all commons are low, segment drive and key scan stop (`seg_drv_o`, `ks_phase_o`, `ks_strobe_o`, `seg_o` low); the next run starts on the first clock of common 0.
- R9: A change on `mode8_i` or `ks_code_i` during a run takes effect only from the next frame start; while idle, the inputs are captured continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode8_i | input | 1 | Geometry select: 0 four commons, 1 eight commons |
| disp_en_i | input | 1 | Display enable |
| osc_run_i | input | 1 | Oscillator running |
| ks_code_i | input | 3 | Key-scan window code P |
| wr_en_i | input | 1 | Display store write enable |
| wr_addr_i | input | 4 | Display store write address |
| wr_data_i | input | 8 | Display store write data |
| com_o | output | 8 | One-hot active common |
| seg_o | output | 20 | Segment on pattern for the active common (low during key scan) |
| seg_drv_o | output | 1 | Segment drive enable (display part) |
| ks_phase_o | output | 1 | Key-scan part flag |
| ks_strobe_o | output | 1 | Key sample strobe, last clock of key scan |
| frame_start_o | output | 1 | First clock of a frame |

## Verification
The assertions take for granted that all inputs are synchronous to `clk` and that the display store holds defined data before the display is enabled, since the store has no reset. The bench fills all sixteen bytes while idle, then changes every input only on the falling edge, including setting changes in the middle of frames and short enable drops in the middle of slots, so that frame-boundary capture and the restart at common 0 are both exercised against a bench model of slot, window and mapping.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  // Setting captured at frame boundaries
  typedef struct packed {
    logic       mode8;
    logic [2:0] ks_code;
  } scan_cfg_t;
endpackage

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [DEPTH*DW-1:0] mem_flat_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign mem_flat_o[i*DW +: DW] = mem_q[i];
  end
endmodule

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer
  import lcd_scan_pkg::*;
#(
  parameter int SLOT4 = 110,
  parameter int SLOT8 = 55,
  parameter int NCOM  = 8,
  localparam int CW   = $clog2(SLOT4 + 1),
  localparam int COMW = $clog2(NCOM)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_i,
  input  scan_cfg_t       cfg_i,
  output scan_cfg_t       cfg_o,
  output logic [COMW-1:0] com_idx_o,
  output logic            ks_phase_o,
  output logic            last_o,
  output logic            first_o
);
  scan_cfg_t       cfg_q;
  logic [CW-1:0]   cnt_q;
  logic [COMW-1:0] com_q;
  logic [CW-1:0]   slot_last;
  logic [CW-1:0]   ks_len;
  logic [CW-1:0]   ks_start;
  logic [COMW-1:0] com_last;
  logic            wrap;

  always_comb begin
    slot_last = cfg_q.mode8 ? CW'(SLOT8 - 1) : CW'(SLOT4 - 1);
    com_last  = cfg_q.mode8 ? COMW'(NCOM - 1) : COMW'(NCOM / 2 - 1);
    ks_len    = cfg_q.mode8 ? CW'({cfg_q.ks_code, 1'b1})
                            : CW'({cfg_q.ks_code, 1'b0}) + CW'(2);
    ks_start  = slot_last - ks_len + CW'(1);
    last_o    = (cnt_q == slot_last);
    wrap      = last_o && (com_q == com_last);
  end

  assign ks_phase_o = (cnt_q >= ks_start);
  assign first_o    = (cnt_q == '0) && (com_q == '0);
  assign cfg_o      = cfg_q;
  assign com_idx_o  = com_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      com_q <= '0;
      cfg_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      com_q <= '0;
      cfg_q <= cfg_i;
    end else if (last_o) begin
      cnt_q <= '0;
      if (wrap) begin
        com_q <= '0;
        cfg_q <= cfg_i;
      end else begin
        com_q <= com_q + COMW'(1);
      end
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && !wrap) |=> $stable(cfg_q));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= slot_last);
endmodule

// File: rtl/lcd_seg_mux.sv
module lcd_seg_mux #(
  parameter int NSEG  = 20,
  parameter int NCOM  = 8,
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int COMW = $clog2(NCOM),
  localparam int HALF = NCOM / 2,
  localparam int HW   = $clog2(HALF),
  localparam int IW   = $clog2(DW)
) (
  input  logic [DEPTH*DW-1:0] mem_i,
  input  logic                mode8_i,
  input  logic [COMW-1:0]     com_i,
  output logic [NSEG-1:0]     seg_o
);
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [DW-1:0] byte4;
    logic [IW-1:0] idx4;
    logic          pix4;
    logic          pix8;

    // four-common geometry: two segments share a byte, one nibble each
    assign byte4 = mem_i[(s/2)*DW +: DW];
    assign idx4  = IW'((s % 2) * HALF) + IW'(com_i[HW-1:0]);
    assign pix4  = byte4[idx4];

    // eight-common geometry: one byte per segment
    if (s < DEPTH) begin : g_b8
      logic [DW-1:0] byte8;
      assign byte8 = mem_i[s*DW +: DW];
      assign pix8  = byte8[IW'(com_i)];
    end else begin : g_none
      assign pix8 = 1'b0;
    end

    assign seg_o[s] = mode8_i ? pix8 : pix4;
  end
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int NSEG  = 20,
  parameter int NCOM  = 8,
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int SLOT4 = 110,
  parameter int SLOT8 = 55,
  localparam int AW   = $clog2(DEPTH),
  localparam int COMW = $clog2(NCOM)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode8_i,
  input  logic            disp_en_i,
  input  logic            osc_run_i,
  input  logic [2:0]      ks_code_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [NCOM-1:0] com_o,
  output logic [NSEG-1:0] seg_o,
  output logic            seg_drv_o,
  output logic            ks_phase_o,
  output logic            ks_strobe_o,
  output logic            frame_start_o
);
  logic                run;
  scan_cfg_t           cfg_in;
  scan_cfg_t           cfg_act;
  logic [COMW-1:0]     com_idx;
  logic                ks_now;
  logic                last_now;
  logic                first_now;
  logic [DEPTH*DW-1:0] mem_flat;
  logic [NSEG-1:0]     seg_pat;

  assign run            = disp_en_i && osc_run_i;
  assign cfg_in.mode8   = mode8_i;
  assign cfg_in.ks_code = ks_code_i;

  lcd_slot_timer #(.SLOT4(SLOT4), .SLOT8(SLOT8), .NCOM(NCOM)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run),
    .cfg_i     (cfg_in),
    .cfg_o     (cfg_act),
    .com_idx_o (com_idx),
    .ks_phase_o(ks_now),
    .last_o    (last_now),
    .first_o   (first_now)
  );

  lcd_disp_ram #(.DEPTH(DEPTH), .DW(DW)) ram_i (
    .clk       (clk),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mem_flat_o(mem_flat)
  );

  lcd_seg_mux #(.NSEG(NSEG), .NCOM(NCOM), .DEPTH(DEPTH), .DW(DW)) mux_i (
    .mem_i  (mem_flat),
    .mode8_i(cfg_act.mode8),
    .com_i  (com_idx),
    .seg_o  (seg_pat)
  );

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      com_o         <= '0;
      seg_o         <= '0;
      seg_drv_o     <= 1'b0;
      ks_phase_o    <= 1'b0;
      ks_strobe_o   <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      com_o         <= NCOM'(1) << com_idx;
      seg_o         <= ks_now ? '0 : seg_pat;
      seg_drv_o     <= !ks_now;
      ks_phase_o    <= ks_now;
      ks_strobe_o   <= last_now;
      frame_start_o <= first_now;
    end
  end

  // R2
  com_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(com_o));

  // R4
  strobe_in_ks_chk: assert property (@(posedge clk) disable iff (rst)
    ks_strobe_o |-> ks_phase_o);

  // R4
  strobe_then_disp_chk: assert property (@(posedge clk) disable iff (rst)
    ks_strobe_o |=> !ks_phase_o);

  // R5
  frame_com0_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (com_o[0] && seg_drv_o));

  // R8
  idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (com_o == '0 && !seg_drv_o && !ks_phase_o && seg_o == '0));
endmodule

// File: tb/lcd_scan_timer_tb_top.sv
module lcd_scan_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode8 = 1'b0, disp_en = 1'b0, osc_run = 1'b0;
  logic [2:0] ks_code = 3'd0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0]  com;
  logic [19:0] seg;
  logic        seg_drv, ks_phase, ks_strobe, frame_start;

  always #4 clk = ~clk;

  lcd_scan_timer dut_i (
    .clk(clk), .rst(rst), .mode8_i(mode8), .disp_en_i(disp_en),
    .osc_run_i(osc_run), .ks_code_i(ks_code), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .com_o(com), .seg_o(seg),
    .seg_drv_o(seg_drv), .ks_phase_o(ks_phase), .ks_strobe_o(ks_strobe),
    .frame_start_o(frame_start)
  );

  int n_chk = 0, n_fail = 0;

  // bench model of the requirements
  int m_cnt = 0, m_com = 0, m_p = 0;
  bit m_mode = 0;
  logic [7:0]  m_ram [16];
  logic [7:0]  e_com = '0;
  logic [19:0] e_seg = '0;
  bit e_drv = 0, e_ks = 0, e_stb = 0, e_fs = 0;

  function automatic int slot_len(bit md);
    return md ? 55 : 110;
  endfunction
  function automatic int ks_len(bit md, int p);
    return md ? 2*p + 1 : 2*p + 2;
  endfunction
  function automatic int n_com(bit md);
    return md ? 8 : 4;
  endfunction
  function automatic logic [19:0] seg_model(bit md, int c);
    logic [19:0] r = '0;
    for (int s = 0; s < 20; s++) begin
      if (md) r[s] = (s < 16) ? m_ram[s][c] : 1'b0;   // R7
      else    r[s] = m_ram[s/2][(s%2)*4 + c];        // R6
    end
    return r;
  endfunction

  always @(posedge clk) begin
    bit run;
    run = disp_en && osc_run;
    if (rst) begin
      {e_com, e_seg, e_drv, e_ks, e_stb, e_fs} = '0;
      m_cnt = 0; m_com = 0; m_mode = 0; m_p = 0;
    end else begin
      if (!run) begin
        {e_com, e_seg, e_drv, e_ks, e_stb, e_fs} = '0;
        m_cnt = 0; m_com = 0; m_mode = mode8; m_p = int'(ks_code);
      end else begin
        bit ksp;
        ksp   = m_cnt >= slot_len(m_mode) - ks_len(m_mode, m_p);
        e_com = 8'(1) << m_com;
        e_ks  = ksp;
        e_drv = !ksp;
        e_stb = (m_cnt == slot_len(m_mode) - 1);
        e_fs  = (m_cnt == 0) && (m_com == 0);
        e_seg = ksp ? '0 : seg_model(m_mode, m_com);
        if (m_cnt == slot_len(m_mode) - 1) begin
          m_cnt = 0;
          if (m_com == n_com(m_mode) - 1) begin
            m_com = 0; m_mode = mode8; m_p = int'(ks_code);
          end else m_com++;
        end else m_cnt++;
      end
      if (wr_en) m_ram[wr_addr] = wr_data;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit idle;
    @(negedge clk);
    idle = (e_com == '0);
    chk(com == e_com, idle ? "R8 com" : "R2/R9 com", 32'(com), 32'(e_com));
    chk(seg == e_seg, idle ? "R8 seg" : (m_mode ? "R7 seg" : "R6 seg"),
        32'(seg), 32'(e_seg));
    chk(ks_phase == e_ks && seg_drv == e_drv, "R3/R9 phase",
        {30'd0, ks_phase, seg_drv}, {30'd0, e_ks, e_drv});
    chk(ks_strobe == e_stb, "R4 strobe", 32'(ks_strobe), 32'(e_stb));
    chk(frame_start == e_fs, "R5 frame", 32'(frame_start), 32'(e_fs));
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic main_flow();
    void'($urandom(32'd20240611));
    run_n(3);
    // R1 reset state
    chk({com, seg, seg_drv, ks_phase, ks_strobe, frame_start} == '0,
        "R1 reset", 32'(seg), 32'd0);
    rst = 1'b0;
    tick();
    chk({com, seg, seg_drv, ks_phase, ks_strobe, frame_start} == '0,
        "R1 after", 32'(com), 32'd0);
    // fill store: walking one across bytes
    for (int a = 0; a < 16; a++) begin
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(1) << (a % 8);
      tick();
    end
    wr_en = 1'b0;
    // four-common geometry, shortest then longest window
    mode8 = 1'b0; ks_code = 3'd0; disp_en = 1'b1; osc_run = 1'b1;
    run_n(900);
    ks_code = 3'd7;                   // R9: mid-frame change
    run_n(900);
    // eight-common geometry
    mode8 = 1'b1; ks_code = 3'd0;
    run_n(1000);
    ks_code = 3'd7;
    run_n(500);
    // R8: display off in mid slot, then oscillator stopped
    disp_en = 1'b0; run_n(20); disp_en = 1'b1; run_n(300);
    osc_run = 1'b0; mode8 = 1'b0; ks_code = 3'd3; run_n(5);
    osc_run = 1'b1; run_n(600);
    // all ones pattern
    for (int a = 0; a < 16; a++) begin
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'hFF; tick();
    end
    wr_en = 1'b0;
    run_n(450);
    // random phase
    for (int it = 0; it < 40; it++) begin
      int len;
      len = 50 + int'($urandom_range(750));
      mode8 = 1'($urandom); ks_code = 3'($urandom);
      for (int i = 0; i < len; i++) begin
        wr_en   = ($urandom_range(7) == 0);
        wr_addr = 4'($urandom); wr_data = 8'($urandom);
        if ($urandom_range(999) == 0) disp_en = 1'b0;
        else if (!disp_en && $urandom_range(3) == 0) disp_en = 1'b1;
        tick();
      end
    end
    wr_en = 1'b0; disp_en = 1'b0;
    run_n(3);
  endtask

  initial begin
    fork
      main_flow();
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule